// File: doc/BRIEF.md
# Table-Coefficient Multiplier

This block multiplies a stream of unsigned 8-bit operands. Each operand carries a mode bit and a 4-bit index. In constant mode the operand is multiplied by a 16-bit coefficient, taken from a 16-entry on-chip table at that index, and the block returns a 24-bit product. In pair mode the operand is multiplied by a second 8-bit operand that arrives with it, and the 16-bit product sits in the low bits of the same 24-bit output. Both modes share one multiplier. The only difference is which value is steered into its wide input.

A separate host port reads and writes table entries while the operand stream keeps running. At reset the table is loaded with a computed image. Entry i holds INIT_BASE + i*INIT_STEP, truncated to the coefficient width. A system can therefore start multiplying before any host write. Results leave a fixed two-register pipeline together with a valid flag. Between valid results the output holds its last value.

Top module: `coef_mult`

## Requirements
- R1: While rst_n is low, and after it is released, out_valid is 0 and out_prod is 0 until the first result. Table entry i holds (INIT_BASE + i*INIT_STEP) mod 2^16, with INIT_BASE = 0x1000 and INIT_STEP = 0x0F13 by default.
- R2: When in_mode = 0 (constant mode), the result is in_a * table[in_sel] as a 24-bit unsigned product.
- R3: When in_mode = 1 (pair mode), the result is in_a * in_b as an unsigned 16-bit value in out_prod[15:0], and out_prod[23:16] is 0.
- R4: An operand presented with in_valid high before clock edge k shows up on out_valid and out_prod right after edge k+1. out_valid equals in_valid delayed by two edges. While out_valid is 0, out_prod keeps its previous value.
- R5: host_we = 1 writes host_wdata into entry host_addr at the clock edge. A multiply that reads the same entry in that same cycle uses the old coefficient, and operands from the next cycle on use the new one.
- R6: After each clock edge, host_rdata holds the entry addressed by host_addr before that edge. If that entry was written at the same edge, host_rdata shows the value from before the write.
- R7: The mode may change from one operand to the next with no idle cycle, and each result follows the mode of its own operand.
- R8: in_b has no effect on the result in constant mode. in_sel and the table contents have no effect on the result in pair mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand qualifier |
| in_mode | input | 1 | 0 = constant mode, 1 = pair mode |
| in_sel | input | 4 | Coefficient table index |
| in_a | input | 8 | First operand |
| in_b | input | 8 | Second operand (pair mode) |
| host_we | input | 1 | Host table write enable |
| host_addr | input | 4 | Host table address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, registered |
| out_valid | output | 1 | Result qualifier |
| out_prod | output | 24 | Product |

## Verification
The bench builds the block with its default parameters: 8-bit operands, 16-bit coefficients, a 16-entry table, and the default reset image. These values let it read every table entry through the host port and reach the full-scale corners, 255 × 0xFFFF and 255 × 255. A bench-side table model tracks each host write one edge after it is issued. The same-cycle collision of a write with a multiply or a read can therefore be predicted exactly, and it is compared on every cycle.

// File: rtl/coef_mult_pkg.sv
package coef_mult_pkg;

    typedef enum logic {
        MODE_CONST = 1'b0,
        MODE_PAIR  = 1'b1
    } mult_mode_e;

endpackage

// File: rtl/coef_store.sv
module coef_store #(
    parameter int          DEPTH     = 16,
    parameter int          COEF_W    = 16,
    parameter int unsigned INIT_BASE = 32'h1000,
    parameter int unsigned INIT_STEP = 32'h0F13,
    localparam int         IDX_W     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [COEF_W-1:0] rd_coef,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [COEF_W-1:0] wr_data,
    output logic [COEF_W-1:0] host_data
);

    typedef logic [DEPTH-1:0][COEF_W-1:0] table_t;

    typedef struct packed {
        table_t            tbl;
        logic [COEF_W-1:0] rdata;
    } store_t;

    function automatic table_t reset_image();
        table_t img;
        for (int i = 0; i < DEPTH; i++) begin
            img[i] = COEF_W'(INIT_BASE + INIT_STEP * i);
        end
        return img;
    endfunction

    localparam table_t RESET_TABLE = reset_image();

    store_t st_d, st_q;

    // The multiply path reads the table combinationally. A write only lands at the
    // edge, so a same-cycle read sees the old entry.
    always_comb begin
        st_d = st_q;
        if (int'(wr_addr) < DEPTH) begin
            st_d.rdata = st_q.tbl[wr_addr];
            if (wr_en) begin
                st_d.tbl[wr_addr] = wr_data;
            end
        end else begin
            st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tbl   <= RESET_TABLE;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_coef   = (int'(rd_idx) < DEPTH) ? st_q.tbl[rd_idx] : '0;
    assign host_data = st_q.rdata;

endmodule

// File: rtl/mult_core.sv
module mult_core
    import coef_mult_pkg::*;
#(
    parameter int  OP_W   = 8,
    parameter int  COEF_W = 16,
    localparam int PROD_W = OP_W + COEF_W,
    localparam int PAIR_W = 2 * OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  mult_mode_e        op_mode,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  logic [COEF_W-1:0] op_coef,
    output logic              res_valid,
    output logic [PROD_W-1:0] res_prod
);

    typedef struct packed {
        logic              valid;
        mult_mode_e        mode;
        logic [OP_W-1:0]   a;
        logic [COEF_W-1:0] wide;
    } stage1_t;

    typedef struct packed {
        logic              valid;
        logic [PROD_W-1:0] prod;
    } stage2_t;

    typedef struct packed {
        stage1_t s1;
        stage2_t s2;
    } pipe_t;

    pipe_t pp_d, pp_q;
    logic [PROD_W-1:0] raw_prod;

    // One shared multiplier. Pair mode zero-extends the second operand into the
    // coefficient-wide input.
    assign raw_prod = PROD_W'(pp_q.s1.a) * PROD_W'(pp_q.s1.wide);

    always_comb begin
        pp_d = pp_q;
        pp_d.s1.valid = op_valid;
        if (op_valid) begin
            pp_d.s1.mode = op_mode;
            pp_d.s1.a    = op_a;
            pp_d.s1.wide = (op_mode == MODE_PAIR) ? COEF_W'(op_b) : op_coef;
        end
        pp_d.s2.valid = pp_q.s1.valid;
        if (pp_q.s1.valid) begin
            if (pp_q.s1.mode == MODE_PAIR) begin
                pp_d.s2.prod = {{(PROD_W-PAIR_W){1'b0}}, raw_prod[PAIR_W-1:0]};
            end else begin
                pp_d.s2.prod = raw_prod;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pp_q <= '0;
        end else begin
            pp_q <= pp_d;
        end
    end

    assign res_valid = pp_q.s2.valid;
    assign res_prod  = pp_q.s2.prod;

endmodule

// File: rtl/coef_mult.sv
module coef_mult
    import coef_mult_pkg::*;
#(
    parameter int          OP_W      = 8,
    parameter int          COEF_W    = 16,
    parameter int          DEPTH     = 16,
    parameter int unsigned INIT_BASE = 32'h1000,
    parameter int unsigned INIT_STEP = 32'h0F13,
    localparam int         IDX_W     = $clog2(DEPTH),
    localparam int         PROD_W    = OP_W + COEF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_mode,
    input  logic [IDX_W-1:0]  in_sel,
    input  logic [OP_W-1:0]   in_a,
    input  logic [OP_W-1:0]   in_b,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [COEF_W-1:0] host_wdata,
    output logic [COEF_W-1:0] host_rdata,
    output logic              out_valid,
    output logic [PROD_W-1:0] out_prod
);

    logic [COEF_W-1:0] sel_coef;
    mult_mode_e        mode_e;

    assign mode_e = mult_mode_e'(in_mode);

    coef_store #(
        .DEPTH     (DEPTH),
        .COEF_W    (COEF_W),
        .INIT_BASE (INIT_BASE),
        .INIT_STEP (INIT_STEP)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (in_sel),
        .rd_coef   (sel_coef),
        .wr_en     (host_we),
        .wr_addr   (host_addr),
        .wr_data   (host_wdata),
        .host_data (host_rdata)
    );

    mult_core #(
        .OP_W   (OP_W),
        .COEF_W (COEF_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (in_valid),
        .op_mode   (mode_e),
        .op_a      (in_a),
        .op_b      (in_b),
        .op_coef   (sel_coef),
        .res_valid (out_valid),
        .res_prod  (out_prod)
    );

endmodule

// File: rtl/coef_mult_checker.sv
module coef_mult_checker #(
    parameter int OP_W   = 8,
    parameter int COEF_W = 16,
    parameter int IDX_W  = 4,
    parameter int PROD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_mode,
    input logic [OP_W-1:0]   in_a,
    input logic [OP_W-1:0]   in_b,
    input logic              host_we,
    input logic [IDX_W-1:0]  host_addr,
    input logic [COEF_W-1:0] host_rdata,
    input logic              out_valid,
    input logic [PROD_W-1:0] out_prod
);

    localparam int PAIR_W = 2 * OP_W;

    // Counts edges since reset, saturating, so $past never reaches into reset.
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    assert_valid_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1 && !out_valid) |-> $stable(out_prod));

    assert_pair_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && out_valid && $past(in_mode, 2)) |->
        (out_prod == PROD_W'(PROD_W'($past(in_a, 2)) * PROD_W'($past(in_b, 2)))));

    assert_pair_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && out_valid && $past(in_mode, 2)) |->
        (out_prod[PROD_W-1:PAIR_W] == '0));

    assert_const_ceiling_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && out_valid && !$past(in_mode, 2)) |->
        (out_prod <= PROD_W'(PROD_W'($past(in_a, 2)) * PROD_W'({COEF_W{1'b1}}))));

    assert_zero_operand_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && out_valid && $past(in_a, 2) == '0) |-> (out_prod == '0));

    assert_read_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && !$past(host_we, 2) &&
         $past(host_addr) == $past(host_addr, 2)) |-> $stable(host_rdata));

endmodule

bind coef_mult coef_mult_checker #(
    .OP_W   (OP_W),
    .COEF_W (COEF_W),
    .IDX_W  (IDX_W),
    .PROD_W (PROD_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_mode    (in_mode),
    .in_a       (in_a),
    .in_b       (in_b),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_rdata (host_rdata),
    .out_valid  (out_valid),
    .out_prod   (out_prod)
);

// File: tb/test_coef_mult.sv
`timescale 1ns/1ps
module test_coef_mult;

    localparam int PW = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_mode = 1'b0;
    logic [3:0]  in_sel = '0;
    logic [7:0]  in_a = '0;
    logic [7:0]  in_b = '0;
    logic        host_we = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        out_valid;
    logic [23:0] out_prod;

    int checks = 0;
    int fails  = 0;

    logic [15:0] model [16];
    logic        prev_v = 1'b0;
    logic [23:0] prev_p = '0;
    string       prev_tag = "R2";
    logic [23:0] last_p = '0;

    always #2 clk = ~clk;

    coef_mult i_coef_mult (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_sel(in_sel), .in_a(in_a), .in_b(in_b), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .out_valid(out_valid), .out_prod(out_prod)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One clock: predict from the current inputs, advance, compare at the falling edge.
    task automatic step(input string tag);
        logic [23:0] cur_p;
        logic [15:0] rd_exp;
        logic [23:0] exp_p;
        cur_p  = in_mode ? PW'(in_a) * PW'(in_b) : PW'(in_a) * PW'(model[in_sel]);
        rd_exp = model[host_addr];
        @(posedge clk);
        @(negedge clk);
        if (host_we) model[host_addr] = host_wdata;
        chk(out_valid == prev_v, "R4", "out_valid", 32'(out_valid), 32'(prev_v));
        exp_p = prev_v ? prev_p : last_p;
        chk(out_prod == exp_p, prev_v ? prev_tag : "R4", "out_prod", 32'(out_prod), 32'(exp_p));
        if (prev_v) last_p = prev_p;
        chk(host_rdata == rd_exp, "R6", "host_rdata", 32'(host_rdata), 32'(rd_exp));
        prev_v   = in_valid;
        prev_p   = cur_p;
        prev_tag = tag;
    endtask

    task automatic op(input logic m, input logic [3:0] s, input logic [7:0] a,
                      input logic [7:0] b, input string tag);
        in_valid = 1'b1; in_mode = m; in_sel = s; in_a = a; in_b = b;
        step(tag);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0; host_we = 1'b0;
        for (int i = 0; i < n; i++) step("R4");
    endtask

    task automatic test_reset();
        chk(out_valid == 1'b0, "R1", "out_valid at reset", 32'(out_valid), 0);
        chk(out_prod == '0, "R1", "out_prod at reset", 32'(out_prod), 0);
        for (int i = 0; i < 16; i++) begin
            host_addr = 4'(i);
            step("R1");
        end
    endtask

    task automatic test_const();
        op(1'b0, 4'd0, 8'd3, 8'd0, "R2");
        op(1'b0, 4'd15, 8'd255, 8'd0, "R2");
        op(1'b0, 4'd7, 8'd0, 8'd99, "R2");
        op(1'b0, 4'd9, 8'd128, 8'd1, "R2");
        host_we = 1'b1; host_addr = 4'd2; host_wdata = 16'hFFFF;
        in_valid = 1'b0; step("R5");
        host_we = 1'b0;
        op(1'b0, 4'd2, 8'd255, 8'd0, "R2");
        idle(2);
    endtask

    task automatic test_pair();
        op(1'b1, 4'd5, 8'd255, 8'd255, "R3");
        op(1'b1, 4'd0, 8'd0, 8'd200, "R3");
        op(1'b1, 4'd3, 8'd17, 8'd19, "R3");
        op(1'b1, 4'd15, 8'd1, 8'd255, "R3");
        idle(2);
    endtask

    task automatic test_collision();
        host_we = 1'b1; host_addr = 4'd3; host_wdata = 16'h8001;
        op(1'b0, 4'd3, 8'd10, 8'd0, "R5");
        host_we = 1'b0;
        op(1'b0, 4'd3, 8'd10, 8'd0, "R5");
        host_we = 1'b1; host_addr = 4'd3; host_wdata = 16'h0042;
        op(1'b0, 4'd3, 8'd200, 8'd0, "R5");
        host_we = 1'b0;
        op(1'b0, 4'd3, 8'd200, 8'd0, "R5");
        idle(2);
    endtask

    task automatic test_host_rw();
        host_we = 1'b1; host_addr = 4'd11; host_wdata = 16'hBEEF;
        in_valid = 1'b0; step("R6");
        host_we = 1'b0; step("R6");
        host_we = 1'b1; host_addr = 4'd11; host_wdata = 16'h1234; step("R6");
        host_we = 1'b1; host_addr = 4'd12; host_wdata = 16'h0001; step("R6");
        host_we = 1'b0; host_addr = 4'd11; step("R6");
        host_addr = 4'd12; step("R6");
    endtask

    task automatic test_alternate();
        for (int i = 0; i < 10; i++) begin
            op(1'(i % 2), 4'(i), 8'(37 * i + 5), 8'(91 - 7 * i), "R7");
        end
        idle(2);
    endtask

    task automatic test_ignored();
        op(1'b0, 4'd6, 8'd77, 8'd0, "R8");
        idle(1);
        op(1'b0, 4'd6, 8'd77, 8'd255, "R8");
        idle(1);
        op(1'b1, 4'd1, 8'd44, 8'd55, "R8");
        host_we = 1'b1; host_addr = 4'd9; host_wdata = 16'hFFFF;
        op(1'b1, 4'd9, 8'd44, 8'd55, "R8");
        host_we = 1'b0;
        op(1'b1, 4'd9, 8'd44, 8'd55, "R8");
        idle(3);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 16'(32'h1000 + 32'h0F13 * i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_const();
        test_pair();
        test_collision();
        test_host_rw();
        test_alternate();
        test_ignored();
        finish_run();
    end

endmodule